// File: doc/BRIEF.md
# ADC Autoscan Input Sequencer

This block steers the input multiplexer of a converter front end that has four analog pins: A+, A−, B+ and B−. A 5-bit configuration field selects the inputs. The field picks one fixed input, either single-ended or a differential pair, or it picks an autoscan list that mixes the two kinds. Software loads this field together with a 2-bit test field through a write strobe. The block keeps both fields in registers. It shows the current selection as a 3-bit input tag and raises an error flag when the configuration code is reserved.

Each conversion-complete strobe moves the selection to the next list entry, and after the last entry it returns to the first. The strobe also loads one result register. That register holds the conversion word, or a reference code when a test mode is active, together with the tag of the input the word came from. A configuration write or a synchronous reset starts the scan again at the first entry.

Top module: `adc_scan_seq`

## Requirements
- R1: After synchronous reset, `sel_tag` is 0 (A+), `cfg_error` is 0 and `res_valid` is 0, with config and test fields cleared.
- R2: The configuration field is {scan, dmode1, dmode0, chsel[1:0]}. Codes 0_0_0_xx give a fixed single-ended selection with `sel_tag` = chsel. The tag values are 0=A+, 1=A−, 2=B+, 3=B−.
- R3: Code 0_0_1_00 gives the fixed pair (A+ − A−), tag 4. Code 0_0_1_01 gives the fixed pair (B+ − B−), tag 5. A fixed selection does not change on a conversion strobe.
- R4: Single-ended scan lists. 1_0_0_01 steps through tags 0,1. 1_0_0_10 steps through 0,1,2. 1_0_0_11 steps through 0,1,2,3. Each list wraps back to its first entry.
- R5: Mixed scan lists. 1_0_1_01 steps through tags 0,5. 1_0_1_10 steps through 0,1,5. Each list wraps.
- R6: Code 1_1_0_01 alternates between tags 4 and 5.
- R7: Every other code is reserved. This covers 0_0_1_1x, every 0_1_x_xx, 1_0_0_00, 1_0_1_00, 1_0_1_11, 1_1_0_00, 1_1_0_1x and all 1_1_1_xx. A reserved code sets `cfg_error` to 1 and holds `sel_tag` at 0, and conversion strobes do not move it.
- R8: A configuration write takes effect at the next clock edge and restarts the list at entry 0. After a strobe is sampled, `sel_tag` shows the next entry in the following cycle.
- R9: Each sampled `conv_done` gives `res_valid` high for exactly one cycle, one cycle later. `res_tag` equals the `sel_tag` that was in effect when the strobe was sampled.
- R10: Test field 00 passes `conv_data` through to `res_data`. Field 01 gives all ones (0xFFF at 12 bits). Field 10 gives only the MSB set (0x800). Field 11 gives zero. The test field in use is the one registered before the strobe.
- R11: When `cfg_wr` and `conv_done` arrive in the same cycle, the result carries the old selection and the old test field. The scan then restarts at entry 0 of the new code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| srst | input | 1 | Synchronous reset, active high |
| cfg_wr | input | 1 | Loads cfg_field and test_field |
| cfg_field | input | 5 | {scan, dmode1, dmode0, chsel[1:0]} |
| test_field | input | 2 | Output word substitution select |
| conv_done | input | 1 | Conversion-complete strobe |
| conv_data | input | DATA_W | Raw conversion word |
| sel_tag | output | 3 | Current input selection tag |
| cfg_error | output | 1 | Registered code is reserved |
| res_valid | output | 1 | Result strobe |
| res_data | output | DATA_W | Result word or reference code |
| res_tag | output | 3 | Input tag of the result |

## Verification
The assertions assume that `srst` is held high across the first clock edges. They also assume that `cfg_wr` and `conv_done` are clean one-cycle-wide levels sampled at the rising edge, and that the inputs carry no X values. The stimulus drives every input on the falling edge from tasks, so it stays within these assumptions. The stimulus sweeps all 32 configuration codes under strobes that arrive back to back and also with gaps. It writes new configurations in the middle of a scan, including in the same cycle as a strobe.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;

   localparam int TAG_W = 3;

   typedef enum logic [TAG_W-1:0] {
      TAG_AP = 3'd0,
      TAG_AM = 3'd1,
      TAG_BP = 3'd2,
      TAG_BM = 3'd3,
      TAG_DA = 3'd4,
      TAG_DB = 3'd5
   } in_tag_e;

   typedef enum logic [1:0] {
      TM_NORMAL = 2'd0,
      TM_POS    = 2'd1,
      TM_MID    = 2'd2,
      TM_NEG    = 2'd3
   } test_e;

   typedef struct packed {
      logic       scan;
      logic       dmode1;
      logic       dmode0;
      logic [1:0] chsel;
   } cfg_t;

endpackage

// File: rtl/scan_cfg_decode.sv
module scan_cfg_decode
   import scan_seq_pkg::*;
#(
   parameter int LIST_MAX = 4,
   localparam int IDX_W = (LIST_MAX > 1) ? $clog2(LIST_MAX) : 1
) (
   input  cfg_t                             cfg,
   output logic [LIST_MAX-1:0][TAG_W-1:0]   entries,
   output logic [IDX_W-1:0]                 last_idx,
   output logic                             reserved
);

   generate
      if (LIST_MAX < 4) begin : g_bad_list
         $error("scan_cfg_decode: LIST_MAX must be at least 4");
      end
   endgenerate

   always_comb begin
      for (int k = 0; k < LIST_MAX; k++) entries[k] = TAG_AP;
      last_idx = '0;
      reserved = 1'b0;
      casez ({cfg.scan, cfg.dmode1, cfg.dmode0, cfg.chsel})
         5'b000??: entries[0] = {1'b0, cfg.chsel};
         5'b00100: entries[0] = TAG_DA;
         5'b00101: entries[0] = TAG_DB;
         5'b10001: begin
            entries[1] = TAG_AM;
            last_idx   = IDX_W'(1);
         end
         5'b10010: begin
            entries[1] = TAG_AM;
            entries[2] = TAG_BP;
            last_idx   = IDX_W'(2);
         end
         5'b10011: begin
            entries[1] = TAG_AM;
            entries[2] = TAG_BP;
            entries[3] = TAG_BM;
            last_idx   = IDX_W'(3);
         end
         5'b10101: begin
            entries[1] = TAG_DB;
            last_idx   = IDX_W'(1);
         end
         5'b10110: begin
            entries[1] = TAG_AM;
            entries[2] = TAG_DB;
            last_idx   = IDX_W'(2);
         end
         5'b11001: begin
            entries[0] = TAG_DA;
            entries[1] = TAG_DB;
            last_idx   = IDX_W'(1);
         end
         default:  reserved = 1'b1;
      endcase
   end

   // R7: a reserved code leaves a one-entry list pinned to A+
   always_comb begin
      if (reserved) begin
         p_reserved_pins_ap_r7: assert (last_idx == '0 && entries[0] == TAG_AP);
      end
   end

endmodule

// File: rtl/scan_stepper.sv
module scan_stepper #(
   parameter int LIST_MAX = 4,
   localparam int IDX_W = (LIST_MAX > 1) ? $clog2(LIST_MAX) : 1
) (
   input  logic             clk,
   input  logic             srst,
   input  logic             restart,
   input  logic             advance,
   input  logic [IDX_W-1:0] last_idx,
   output logic [IDX_W-1:0] idx
);

   always_ff @(posedge clk) begin
      if (srst || restart) begin
         idx <= '0;
      end else if (advance) begin
         idx <= (idx == last_idx) ? '0 : idx + 1'b1;
      end
   end

   // R8: a configuration write returns the list to entry 0
   p_restart_zero_r8: assert property (@(posedge clk) disable iff (srst)
      restart |=> idx == '0);

   // R4: the position never runs past the end of the active list
   p_idx_bounded_r4: assert property (@(posedge clk) disable iff (srst)
      idx <= last_idx);

   // R8: with no strobe and no write, the position holds
   p_idx_hold_r8: assert property (@(posedge clk) disable iff (srst)
      !restart && !advance |=> $stable(idx));

endmodule

// File: rtl/scan_result_tag.sv
module scan_result_tag
   import scan_seq_pkg::*;
#(
   parameter int DATA_W   = 12,
   parameter bit SUBST_EN = 1'b1
) (
   input  logic              clk,
   input  logic              srst,
   input  logic              conv_done,
   input  logic [DATA_W-1:0] conv_data,
   input  logic [TAG_W-1:0]  cur_tag,
   input  test_e             test_mode,
   output logic              res_valid,
   output logic [DATA_W-1:0] res_data,
   output logic [TAG_W-1:0]  res_tag
);

   localparam logic [DATA_W-1:0] CODE_POS = '1;
   localparam logic [DATA_W-1:0] CODE_MID = {1'b1, {(DATA_W-1){1'b0}}};
   localparam logic [DATA_W-1:0] CODE_NEG = '0;

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("scan_result_tag: DATA_W must be at least 2");
      end
   endgenerate

   logic [DATA_W-1:0] word_nxt;

   generate
      if (SUBST_EN) begin : g_subst
         always_comb begin
            unique case (test_mode)
               TM_POS:  word_nxt = CODE_POS;
               TM_MID:  word_nxt = CODE_MID;
               TM_NEG:  word_nxt = CODE_NEG;
               default: word_nxt = conv_data;
            endcase
         end
      end else begin : g_pass
         assign word_nxt = conv_data;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (srst) begin
         res_valid <= 1'b0;
         res_data  <= '0;
         res_tag   <= '0;
      end else begin
         res_valid <= conv_done;
         if (conv_done) begin
            res_data <= word_nxt;
            res_tag  <= cur_tag;
         end
      end
   end

   // R9: one result strobe per sampled conversion, one cycle later
   p_valid_follows_r9: assert property (@(posedge clk) disable iff (srst)
      conv_done |=> res_valid);
   p_valid_quiet_r9: assert property (@(posedge clk) disable iff (srst)
      !conv_done |=> !res_valid);

   // R9: the tag is the selection that was in effect at the strobe
   p_tag_capture_r9: assert property (@(posedge clk) disable iff (srst)
      conv_done |=> res_tag == $past(cur_tag));

   // R10: the positive reference gives all ones
   p_pos_code_r10: assert property (@(posedge clk) disable iff (srst)
      conv_done && test_mode == TM_POS && SUBST_EN |=> res_data == CODE_POS);

   // R10: normal mode passes the word through
   p_normal_pass_r10: assert property (@(posedge clk) disable iff (srst)
      conv_done && test_mode == TM_NORMAL |=> res_data == $past(conv_data));

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
   import scan_seq_pkg::*;
#(
   parameter int DATA_W   = 12,
   parameter int LIST_MAX = 4,
   parameter bit SUBST_EN = 1'b1
) (
   input  logic              clk,
   input  logic              srst,
   input  logic              cfg_wr,
   input  logic [4:0]        cfg_field,
   input  logic [1:0]        test_field,
   input  logic              conv_done,
   input  logic [DATA_W-1:0] conv_data,
   output logic [2:0]        sel_tag,
   output logic              cfg_error,
   output logic              res_valid,
   output logic [DATA_W-1:0] res_data,
   output logic [2:0]        res_tag
);

   localparam int IDX_W = (LIST_MAX > 1) ? $clog2(LIST_MAX) : 1;

   cfg_t  cfg_q;
   test_e test_q;

   always_ff @(posedge clk) begin
      if (srst) begin
         cfg_q  <= '0;
         test_q <= TM_NORMAL;
      end else if (cfg_wr) begin
         cfg_q  <= cfg_t'(cfg_field);
         test_q <= test_e'(test_field);
      end
   end

   logic [LIST_MAX-1:0][TAG_W-1:0] entries;
   logic [IDX_W-1:0]               last_idx;
   logic [IDX_W-1:0]               idx;

   scan_cfg_decode #(
      .LIST_MAX (LIST_MAX)
   ) decode_i (
      .cfg      (cfg_q),
      .entries  (entries),
      .last_idx (last_idx),
      .reserved (cfg_error)
   );

   scan_stepper #(
      .LIST_MAX (LIST_MAX)
   ) step_i (
      .clk      (clk),
      .srst     (srst),
      .restart  (cfg_wr),
      .advance  (conv_done),
      .last_idx (last_idx),
      .idx      (idx)
   );

   assign sel_tag = entries[idx];

   scan_result_tag #(
      .DATA_W   (DATA_W),
      .SUBST_EN (SUBST_EN)
   ) result_i (
      .clk       (clk),
      .srst      (srst),
      .conv_done (conv_done),
      .conv_data (conv_data),
      .cur_tag   (sel_tag),
      .test_mode (test_q),
      .res_valid (res_valid),
      .res_data  (res_data),
      .res_tag   (res_tag)
   );

   // R7: a reserved code holds the selection at A+
   p_err_holds_ap_r7: assert property (@(posedge clk) disable iff (srst)
      cfg_error |-> sel_tag == TAG_AP);

   // R3: a fixed differential code does not move on a strobe
   p_fixed_diff_r3: assert property (@(posedge clk) disable iff (srst)
      (cfg_q == 5'b00100 || cfg_q == 5'b00101) && conv_done && !cfg_wr
      |=> $stable(sel_tag));

   // R11: write and strobe together: old tag on the result, new list at entry 0
   p_collide_r11: assert property (@(posedge clk) disable iff (srst)
      cfg_wr && conv_done |=> res_tag == $past(sel_tag) && idx == '0);

   // R2: selection tags stay inside the six defined codes
   p_tag_legal_r2: assert property (@(posedge clk) disable iff (srst)
      sel_tag <= 3'd5);

endmodule

// File: tb/adc_scan_seq_tb_top.sv
module adc_scan_seq_tb_top;

   localparam int DW = 12;

   logic          clk = 1'b0;
   logic          srst = 1'b1;
   logic          cfg_wr = 1'b0;
   logic [4:0]    cfg_field = '0;
   logic [1:0]    test_field = '0;
   logic          conv_done = 1'b0;
   logic [DW-1:0] conv_data = '0;
   logic [2:0]    sel_tag;
   logic          cfg_error;
   logic          res_valid;
   logic [DW-1:0] res_data;
   logic [2:0]    res_tag;

   always #4 clk = ~clk;

   adc_scan_seq #(.DATA_W(DW)) dut_i (
      .clk        (clk),
      .srst       (srst),
      .cfg_wr     (cfg_wr),
      .cfg_field  (cfg_field),
      .test_field (test_field),
      .conv_done  (conv_done),
      .conv_data  (conv_data),
      .sel_tag    (sel_tag),
      .cfg_error  (cfg_error),
      .res_valid  (res_valid),
      .res_data   (res_data),
      .res_tag    (res_tag)
   );

   int    checks = 0;
   int    errors = 0;
   string cur_req = "R1";
   bit    chk_en = 1'b0;
   bit    done = 1'b0;

   // Scan list per code: index -1 returns the length, 0 means reserved.
   function automatic int plan_at(input logic [4:0] c, input int i);
      int q[$];
      case (c)
         5'b00000: q = {0};
         5'b00001: q = {1};
         5'b00010: q = {2};
         5'b00011: q = {3};
         5'b00100: q = {4};
         5'b00101: q = {5};
         5'b10001: q = {0, 1};
         5'b10010: q = {0, 1, 2};
         5'b10011: q = {0, 1, 2, 3};
         5'b10101: q = {0, 5};
         5'b10110: q = {0, 1, 5};
         5'b11001: q = {4, 5};
         default:  q = {};
      endcase
      if (i < 0) return q.size();
      if (q.size() == 0) return 0;
      return q[i];
   endfunction

   function automatic string req_of(input logic [4:0] c);
      if (plan_at(c, -1) == 0) return "R7";
      if (c[4:2] == 3'b000) return "R2";
      if (c[4:2] == 3'b001) return "R3";
      if (c[4:2] == 3'b100) return "R4";
      if (c[4:2] == 3'b101) return "R5";
      return "R6";
   endfunction

   function automatic logic [DW-1:0] word_of(input int t, input logic [DW-1:0] d);
      if (t == 1) return {DW{1'b1}};
      if (t == 2) return logic'(1) << (DW - 1);
      if (t == 3) return '0;
      return d;
   endfunction

   // behavioural model
   logic [4:0]    m_cfg = '0;
   int            m_test = 0;
   int            m_pos = 0;
   bit            m_valid = 1'b0;
   int            m_tag = 0;
   logic [DW-1:0] m_data = '0;

   always @(posedge clk) begin
      if (srst) begin
         m_cfg = '0; m_test = 0; m_pos = 0; m_valid = 1'b0;
      end else begin
         int n;
         m_valid = conv_done;
         if (conv_done) begin
            m_tag  = plan_at(m_cfg, m_pos);
            m_data = word_of(m_test, conv_data);
         end
         if (cfg_wr) begin
            m_cfg = cfg_field; m_test = int'(test_field); m_pos = 0;
         end else if (conv_done) begin
            n = plan_at(m_cfg, -1);
            m_pos = (n == 0) ? 0 : (m_pos + 1) % n;
         end
      end
   end

   task automatic check(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (chk_en && !srst) begin
         bit rsv;
         rsv = (plan_at(m_cfg, -1) == 0);
         check(cur_req, "sel_tag", int'(sel_tag), rsv ? 0 : plan_at(m_cfg, m_pos));
         check(rsv ? "R7" : cur_req, "cfg_error", int'(cfg_error), int'(rsv));
         check("R9", "res_valid", int'(res_valid), int'(m_valid));
         if (m_valid) begin
            check("R9", "res_tag", int'(res_tag), m_tag);
            check("R10", "res_data", int'(res_data), int'(m_data));
         end
      end
   end

   task automatic write_cfg(input logic [4:0] c, input logic [1:0] t);
      cfg_wr = 1'b1; cfg_field = c; test_field = t;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic convert(input int n, input bit gaps);
      for (int k = 0; k < n; k++) begin
         conv_done = 1'b1;
         conv_data = DW'($urandom);
         @(negedge clk);
         conv_done = 1'b0;
         if (gaps) repeat ($urandom_range(0, 2)) @(negedge clk);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual running expected done");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      srst = 1'b0;
      @(negedge clk);
      cur_req = "R1";
      check("R1", "reset sel_tag", int'(sel_tag), 0);
      check("R1", "reset cfg_error", int'(cfg_error), 0);
      check("R1", "reset res_valid", int'(res_valid), 0);
      chk_en = 1'b1;

      // every code, back to back and with gaps (R2 R3 R4 R5 R6 R7)
      for (int c = 0; c < 32; c++) begin
         cur_req = req_of(5'(c));
         write_cfg(5'(c), 2'b00);
         convert(6, 1'b0);
         convert(5, 1'b1);
      end

      // R8: rewrite in the middle of a scan restarts it
      cur_req = "R8";
      write_cfg(5'b10011, 2'b00);
      convert(2, 1'b0);
      write_cfg(5'b10110, 2'b00);
      convert(4, 1'b1);
      write_cfg(5'b10110, 2'b00);
      convert(1, 1'b0);

      // R10: test-mode substitution on a four-entry scan
      for (int t = 0; t < 4; t++) begin
         cur_req = "R10";
         write_cfg(5'b10011, 2'(t));
         convert(5, 1'b1);
      end

      // R11: write and strobe in the same cycle
      cur_req = "R11";
      write_cfg(5'b10010, 2'b01);
      convert(1, 1'b0);
      cfg_wr = 1'b1; cfg_field = 5'b11001; test_field = 2'b00;
      conv_done = 1'b1; conv_data = 12'h5A5;
      @(negedge clk);
      cfg_wr = 1'b0; conv_done = 1'b0;
      convert(3, 1'b0);
      cfg_wr = 1'b1; cfg_field = 5'b11111; test_field = 2'b10;
      conv_done = 1'b1; conv_data = 12'h123;
      @(negedge clk);
      cfg_wr = 1'b0; conv_done = 1'b0;
      convert(2, 1'b0);

      // R1: reset in the middle of a scan
      cur_req = "R1";
      write_cfg(5'b10011, 2'b11);
      convert(2, 1'b0);
      srst = 1'b1;
      @(negedge clk);
      srst = 1'b0;
      @(negedge clk);
      check("R1", "reset sel_tag", int'(sel_tag), 0);
      check("R1", "reset cfg_error", int'(cfg_error), 0);
      check("R1", "reset res_valid", int'(res_valid), 0);
      convert(2, 1'b0);
      repeat (3) @(negedge clk);
      finish_run();
   end

endmodule